// File: doc/BRIEF.md
# Primary/Alternate Descriptor Sequencer

This block sits above a single-descriptor transfer engine for one channel of a DMA controller and decides which control structure drives each leg of a transfer. Every channel owns two four-word structures in memory: a primary one and an alternate one. The alternate table sits directly after the primary table, and the table base is aligned to a 1024-byte boundary. On a start pulse the sequencer fetches the selected structure and decodes its mode. It then either hands the structure to the engine for a data leg, or copies the next task entry of a scatter-gather list into the alternate slot itself. Once a leg is complete it writes the updated control word back.

The sequencer handles three kinds of chaining. In ping-pong operation it swaps structures after every leg, so software can refill the idle buffer. In scatter-gather operation the primary structure acts as a copier: each of its legs moves one four-word task into the alternate slot, and the alternate task then runs. This repeats until a task in single-shot mode (basic or auto) finishes the channel. A fetched structure whose mode is stop ends the channel at once.

Top module: `desc_seq`

## Requirements
- R1: During and after reset, `eng_go`, `chan_done`, `mem_re`, `mem_we` and `active_alt` are 0.
- R2: The primary structure of channel CH is at B + 16*CH, where B is `tbl_base` with its low 10 bits forced to zero. The alternate structure is at the primary address plus 16*NCH. Word offsets within a structure are +0 source end, +4 destination end, +8 control and +12 spare. A read returns data one cycle after `mem_re`.
- R3: A start pulse picks the alternate structure when `alt_start` is 1 and the primary otherwise. `active_alt` shows the structure in use and holds steady while an engine leg runs.
- R4: The control word holds the mode in bits [2:0], the burst-tail flag in bit 3 and the item count minus one in bits [13:4]. Mode 1 (basic) or mode 2 (auto) gives exactly one `eng_go` pulse carrying the fetched source end, destination end and control words. After `eng_done`, the control word is written back with bits [2:0] and [13:4] cleared and all other bits unchanged. `chan_done` then pulses for one cycle.
- R5: If the fetched structure has mode 0 (stop), `chan_done` pulses without any engine leg and without any memory write.
- R6: Mode 3 (ping-pong) runs a leg, writes back the control word as in R4, and switches to the other structure. The channel ends when the structure fetched next is in stop mode.
- R7: A primary structure with bit 2 of its mode set (4 to 7) is a copy leg. Let n be the count field plus one. The block reads four words starting at source end minus 4*(n-1), stepping by 4, and writes them to the alternate slot words 0 to 3. It then writes the primary control word back with the count reduced by four, or as stop (mode and count cleared) when nothing remains. The alternate structure runs next.
- R8: An alternate structure with mode 4 to 7 is a list task. After its engine leg the sequencer returns to the primary structure. A list task in mode 1 or 2 ends the channel after its leg.
- R9: `eng_burst` is 1 for alternate legs that follow the final copy of a primary structure in mode 6 or 7 whose bit 3 is set. In every other case it is 0, including mode 4 or 5 with bit 3 set.
- R10: A start pulse while the channel is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a channel run (one-cycle pulse) |
| alt_start | input | 1 | Run begins from the alternate structure |
| tbl_base | input | DW | Control table base address (low 10 bits ignored) |
| mem_re | output | 1 | Descriptor memory read strobe |
| mem_we | output | 1 | Descriptor memory write strobe |
| mem_addr | output | DW | Byte address for read or write |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_re` |
| eng_go | output | 1 | Launch one engine leg |
| eng_src_end | output | DW | Source end address of the leg |
| eng_dst_end | output | DW | Destination end address of the leg |
| eng_ctl | output | DW | Control word of the leg |
| eng_burst | output | 1 | Engine must accept only burst requests |
| eng_done | input | 1 | Engine finished the launched leg |
| active_alt | output | 1 | Structure in use: 1 alternate, 0 primary |
| chan_done | output | 1 | One-cycle pulse when the channel stops |

## Verification
A plain basic leg read through a misaligned table base shows that the fetch address is aligned and that the words are placed correctly. An auto leg started from the alternate structure separates the two start selections. A stop structure on its own confirms that neither an engine leg nor a memory write takes place. A two-leg ping-pong run separates switching from ending. Two three-task list runs tell the tail-burst case apart from the case without it: the primary is in mode 6 with the flag in one and in mode 4 with the flag in the other. They also show the copy order, the source stepping and the count written back. A second start pulse during a leg shows that restarts are ignored.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
   localparam logic [2:0] MD_STOP  = 3'd0;
   localparam logic [2:0] MD_BASIC = 3'd1;
   localparam logic [2:0] MD_AUTO  = 3'd2;
   localparam int SLOT_WORDS = 4;
   localparam int SLOT_BYTES = 4 * SLOT_WORDS;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_EVAL, S_GO, S_WAIT, S_CP_RD, S_CP_WR, S_WB, S_DONE
   } seq_state_e;
endpackage

// File: rtl/desc_seq_addr.sv
module desc_seq_addr
   import desc_seq_pkg::*;
#(
   parameter int DW         = 32,
   parameter int NCH        = 8,
   parameter int CH         = 0,
   parameter int ALIGN_BITS = 10
) (
   input  logic [DW-1:0] tbl_base,
   input  logic          sel,
   output logic [DW-1:0] pri_base,
   output logic [DW-1:0] alt_base,
   output logic [DW-1:0] cur_base
);
   localparam logic [DW-1:0] ALIGN_MASK = DW'((64'd1 << ALIGN_BITS) - 1);
   localparam logic [DW-1:0] CH_OFF     = DW'(CH * SLOT_BYTES);
   localparam logic [DW-1:0] TBL_BYTES  = DW'(NCH * SLOT_BYTES);

   if (CH >= NCH) begin : g_bad_ch
      $error("channel index outside table");
   end
   if (2 * NCH * SLOT_BYTES > (1 << ALIGN_BITS)) begin : g_bad_align
      $error("both tables must fit inside the alignment window");
   end

   logic [DW-1:0] base_al;
   assign base_al  = tbl_base & ~ALIGN_MASK;
   assign pri_base = base_al + CH_OFF;
   assign alt_base = pri_base + TBL_BYTES;
   assign cur_base = sel ? alt_base : pri_base;
endmodule

// File: rtl/desc_seq_leg.sv
module desc_seq_leg
   import desc_seq_pkg::*;
#(
   parameter int DW      = 32,
   parameter int CNT_LSB = 4,
   parameter int CNT_W   = 10
) (
   input  logic [DW-1:0] ctl,
   input  logic [DW-1:0] src_end,
   input  logic          copy_leg,
   output logic [DW-1:0] copy_src,
   output logic [DW-1:0] ctl_after,
   output logic          leg_last
);
   localparam int NW = CNT_W + 1;

   logic [CNT_W-1:0] cnt_field;
   logic [NW-1:0]    items;
   logic [NW-1:0]    rem;

   assign cnt_field = ctl[CNT_LSB +: CNT_W];
   assign items     = NW'(cnt_field) + NW'(1);
   assign rem       = (items > NW'(SLOT_WORDS)) ? items - NW'(SLOT_WORDS) : '0;
   assign leg_last  = (rem == '0);
   assign copy_src  = src_end - (DW'(cnt_field) << 2);

   always_comb begin
      ctl_after                     = ctl;
      ctl_after[2:0]                = MD_STOP;
      ctl_after[CNT_LSB +: CNT_W]   = '0;
      if (copy_leg && !leg_last) begin
         ctl_after[2:0]              = ctl[2:0];
         ctl_after[CNT_LSB +: CNT_W] = CNT_W'(rem - NW'(1));
      end
   end
endmodule

// File: rtl/desc_seq.sv
module desc_seq
   import desc_seq_pkg::*;
#(
   parameter int DW         = 32,
   parameter int NCH        = 8,
   parameter int CH         = 0,
   parameter int ALIGN_BITS = 10,
   parameter int CNT_LSB    = 4,
   parameter int CNT_W      = 10,
   parameter bit TAIL_BURST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          alt_start,
   input  logic [DW-1:0] tbl_base,
   output logic          mem_re,
   output logic          mem_we,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          eng_go,
   output logic [DW-1:0] eng_src_end,
   output logic [DW-1:0] eng_dst_end,
   output logic [DW-1:0] eng_ctl,
   output logic          eng_burst,
   input  logic          eng_done,
   output logic          active_alt,
   output logic          chan_done
);
   localparam int KW = $clog2(SLOT_WORDS);

   if (CNT_LSB < 4 || CNT_LSB + CNT_W > DW) begin : g_bad_field
      $error("count field overlaps mode/flag bits or exceeds word");
   end
   if (DW < ALIGN_BITS + 1) begin : g_bad_dw
      $error("word too narrow for alignment");
   end

   seq_state_e    state;
   logic          sel;
   logic [1:0]    idx;
   logic [KW-1:0] k;
   logic [DW-1:0] w_src, w_dst, w_ctl;
   logic          tail_q;

   logic [DW-1:0] pri_base, alt_base, cur_base;
   logic [DW-1:0] copy_src, ctl_after;
   logic          leg_last;
   logic [2:0]    mode;
   logic          copy_leg;

   assign mode     = w_ctl[2:0];
   assign copy_leg = !sel && w_ctl[2];

   desc_seq_addr #(.DW(DW), .NCH(NCH), .CH(CH), .ALIGN_BITS(ALIGN_BITS)) u_addr (
      .tbl_base (tbl_base),
      .sel      (sel),
      .pri_base (pri_base),
      .alt_base (alt_base),
      .cur_base (cur_base)
   );

   desc_seq_leg #(.DW(DW), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_leg (
      .ctl       (w_ctl),
      .src_end   (w_src),
      .copy_leg  (copy_leg),
      .copy_src  (copy_src),
      .ctl_after (ctl_after),
      .leg_last  (leg_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         sel   <= 1'b0;
         idx   <= '0;
         k     <= '0;
         w_src <= '0;
         w_dst <= '0;
         w_ctl <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               sel   <= alt_start;
               idx   <= '0;
               state <= S_FETCH;
            end
            S_FETCH: begin
               case (idx)
                  2'd1:    w_src <= mem_rdata;
                  2'd2:    w_dst <= mem_rdata;
                  2'd3:    w_ctl <= mem_rdata;
                  default: ;
               endcase
               idx <= idx + 2'd1;
               if (idx == 2'd3) state <= S_EVAL;
            end
            S_EVAL: begin
               if (mode == MD_STOP) state <= S_DONE;
               else if (copy_leg) begin
                  k     <= '0;
                  state <= S_CP_RD;
               end else state <= S_GO;
            end
            S_GO:    state <= S_WAIT;
            S_WAIT:  if (eng_done) state <= S_WB;
            S_CP_RD: state <= S_CP_WR;
            S_CP_WR: begin
               k     <= k + KW'(1);
               state <= (k == KW'(SLOT_WORDS - 1)) ? S_WB : S_CP_RD;
            end
            S_WB: begin
               if (!copy_leg && (mode == MD_BASIC || mode == MD_AUTO)) state <= S_DONE;
               else begin
                  sel   <= ~sel;
                  idx   <= '0;
                  state <= S_FETCH;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   if (TAIL_BURST) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tail_q <= 1'b0;
         else if (state == S_IDLE && start) tail_q <= 1'b0;
         else if (state == S_WB && copy_leg && leg_last && w_ctl[1] && w_ctl[3])
            tail_q <= 1'b1;
      end
   end else begin : g_no_tail
      assign tail_q = 1'b0;
   end

   always_comb begin
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         S_FETCH: begin
            mem_re   = (idx != 2'd3);
            mem_addr = cur_base + (DW'(idx) << 2);
         end
         S_CP_RD: begin
            mem_re   = 1'b1;
            mem_addr = copy_src + (DW'(k) << 2);
         end
         S_CP_WR: begin
            mem_we    = 1'b1;
            mem_addr  = alt_base + (DW'(k) << 2);
            mem_wdata = mem_rdata;
         end
         S_WB: begin
            mem_we    = 1'b1;
            mem_addr  = cur_base + DW'(8);
            mem_wdata = ctl_after;
         end
         default: ;
      endcase
   end

   assign eng_go      = (state == S_GO);
   assign eng_src_end = w_src;
   assign eng_dst_end = w_dst;
   assign eng_ctl     = w_ctl;
   assign eng_burst   = tail_q && sel;
   assign active_alt  = sel;
   assign chan_done   = (state == S_DONE);
   assign pri_unused  = 1'b0;
   wire   pri_unused;
   wire   unused_ok = ^pri_base ^ pri_unused;
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk #(
   parameter int DW         = 32,
   parameter int NCH        = 8,
   parameter int CH         = 0,
   parameter int ALIGN_BITS = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] tbl_base,
   input logic          mem_re,
   input logic          mem_we,
   input logic [DW-1:0] mem_addr,
   input logic          eng_go,
   input logic          eng_burst,
   input logic          active_alt,
   input logic          chan_done
);
   localparam logic [DW-1:0] MASK = DW'((64'd1 << ALIGN_BITS) - 1);
   logic [DW-1:0] pri_b, alt_b;
   assign pri_b = (tbl_base & ~MASK) + DW'(CH * 16);
   assign alt_b = pri_b + DW'(NCH * 16);

   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we)); // R2
   AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |=> !eng_go); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_done |=> !chan_done); // R4
   AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |=> $stable(active_alt)); // R3
   AST_BURST_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      eng_burst |-> active_alt); // R9
   AST_COPY_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !active_alt && mem_addr != pri_b + DW'(8))
      |-> (mem_addr >= alt_b && mem_addr < alt_b + DW'(16))); // R7
endmodule

bind desc_seq desc_seq_chk #(.DW(DW), .NCH(NCH), .CH(CH), .ALIGN_BITS(ALIGN_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .mem_re(mem_re), .mem_we(mem_we),
   .mem_addr(mem_addr), .eng_go(eng_go), .eng_burst(eng_burst),
   .active_alt(active_alt), .chan_done(chan_done)
);

// File: tb/tb_desc_seq.sv
module tb_desc_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] PRI = 32'h400;
   localparam logic [31:0] ALT = 32'h480;
   localparam logic [31:0] LST = 32'h600;

   logic clk = 0, rst_n = 0, start = 0, alt_start = 0, eng_done = 0;
   logic [31:0] tbl_base = 32'h4A7;
   logic mem_re, mem_we, eng_go, eng_burst, active_alt, chan_done;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, eng_src_end, eng_dst_end, eng_ctl;
   logic h_we = 0;
   logic [31:0] h_addr = 0, h_data = 0;
   logic [31:0] mem [0:1023];
   int wr_count = 0, eng_cnt = 0, done_cnt = 0, cycles = 0;
   int checks = 0, errors = 0;
   logic [97:0] exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .alt_start(alt_start), .tbl_base(tbl_base),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .eng_go(eng_go), .eng_src_end(eng_src_end),
      .eng_dst_end(eng_dst_end), .eng_ctl(eng_ctl), .eng_burst(eng_burst),
      .eng_done(eng_done), .active_alt(active_alt), .chan_done(chan_done)
   );

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) begin
         mem[mem_addr[11:2]] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
      if (h_we) mem[h_addr[11:2]] <= h_data;
   end

   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (eng_cnt != 0) begin
         eng_cnt <= eng_cnt - 1;
         if (eng_cnt == 1) eng_done <= 1'b1;
      end else if (eng_go) eng_cnt <= 3;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected engine legs
   always @(negedge clk) begin
      cycles++;
      if (rst_n && chan_done) done_cnt++;
      if (rst_n && eng_go) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected leg actual=%h expected=none",
                     {eng_src_end, eng_dst_end, eng_ctl, active_alt, eng_burst});
         end else begin
            logic [97:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({eng_src_end, eng_dst_end, eng_ctl, active_alt, eng_burst} !== e) begin
               errors++;
               $display("FAIL %s leg actual=%h expected=%h", t,
                        {eng_src_end, eng_dst_end, eng_ctl, active_alt, eng_burst}, e);
            end
         end
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic push(string t, logic [31:0] s, logic [31:0] d, logic [31:0] c, logic a, logic b);
      exp_q.push_back({s, d, c, a, b});
      tag_q.push_back(t);
   endtask

   function automatic logic [31:0] mkctl(int mode, int items, int burst, int hi);
      return (32'(hi) << 16) | (32'(items - 1) << 4) | (32'(burst) << 3) | 32'(mode);
   endfunction

   task automatic hwr(logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      h_we = 1; h_addr = a; h_data = d;
      @(negedge clk);
      h_we = 0;
   endtask

   task automatic slot(logic [31:0] a, logic [31:0] s, logic [31:0] d, logic [31:0] c, logic [31:0] sp);
      hwr(a, s); hwr(a + 4, d); hwr(a + 8, c); hwr(a + 12, sp);
   endtask

   task automatic run(logic alt, string t);
      int target;
      target = done_cnt + 1;
      @(negedge clk);
      alt_start = alt; start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 3000 && done_cnt < target; i++) @(negedge clk);
      repeat (5) @(negedge clk);
      chk({t, " done count"}, 32'(done_cnt), 32'(target));
      chk({t, " legs left"}, 32'(exp_q.size()), 0);
   endtask

   task automatic list_setup();
      slot(LST,      32'hA0, 32'hB0, mkctl(5, 3, 0, 1), 32'h5A0);
      slot(LST + 16, 32'hA1, 32'hB1, mkctl(7, 2, 0, 2), 32'h5A1);
      slot(LST + 32, 32'hA2, 32'hB2, mkctl(1, 6, 0, 3), 32'h5A2);
   endtask

   initial begin
      int d0, w0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 eng_go", 32'(eng_go), 0);
      chk("R1 chan_done", 32'(chan_done), 0);
      chk("R1 mem strobes", 32'({mem_re, mem_we}), 0);
      chk("R1 active_alt", 32'(active_alt), 0);
      rst_n = 1;

      // R2/R4: basic leg from primary, misaligned base; R10: restart ignored
      slot(PRI, 32'h1000_0010, 32'h2000_0020, mkctl(1, 8, 0, 8'hAB), 0);
      push("R2 R4 basic", 32'h1000_0010, 32'h2000_0020, mkctl(1, 8, 0, 8'hAB), 0, 0);
      d0 = done_cnt;
      @(negedge clk);
      alt_start = 0; start = 1;
      @(negedge clk);
      start = 0;
      repeat (6) @(negedge clk);
      start = 1; // R10: second start while running
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 200 && done_cnt == d0; i++) @(negedge clk);
      repeat (30) @(negedge clk);
      chk("R10 single completion", 32'(done_cnt - d0), 1);
      chk("R4 writeback", mem[PRI[11:2] + 2], 32'h00AB_0000);

      // R3: auto leg from alternate
      slot(ALT, 32'h3000_0000, 32'h4000_0000, mkctl(2, 16, 0, 8'hC1), 0);
      push("R3 auto alt", 32'h3000_0000, 32'h4000_0000, mkctl(2, 16, 0, 8'hC1), 1, 0);
      run(1, "R3");
      chk("R3 active_alt", 32'(active_alt), 1);
      chk("R4 alt writeback", mem[ALT[11:2] + 2], 32'h00C1_0000);

      // R5: stop structure (primary is already stop)
      w0 = wr_count;
      run(0, "R5");
      chk("R5 no writes", 32'(wr_count - w0), 0);

      // R6: ping-pong, two legs then stop
      hwr(PRI + 8, mkctl(3, 4, 0, 8'h11));
      hwr(ALT + 8, mkctl(3, 2, 0, 8'h22));
      push("R6 pp pri", 32'h1000_0010, 32'h2000_0020, mkctl(3, 4, 0, 8'h11), 0, 0);
      push("R6 pp alt", 32'h3000_0000, 32'h4000_0000, mkctl(3, 2, 0, 8'h22), 1, 0);
      run(0, "R6");
      chk("R6 pri wb", mem[PRI[11:2] + 2], 32'h0011_0000);
      chk("R6 alt wb", mem[ALT[11:2] + 2], 32'h0022_0000);
      chk("R6 ends on primary", 32'(active_alt), 0);

      // R7/R8/R9: peripheral list with tail burst
      list_setup();
      slot(PRI, LST + 44, ALT + 12, mkctl(6, 12, 1, 8'h77), 0);
      push("R8 task0", 32'hA0, 32'hB0, mkctl(5, 3, 0, 1), 1, 0);
      push("R8 task1", 32'hA1, 32'hB1, mkctl(7, 2, 0, 2), 1, 0);
      push("R9 task2 burst", 32'hA2, 32'hB2, mkctl(1, 6, 0, 3), 1, 1);
      run(0, "R7");
      chk("R7 pri final", mem[PRI[11:2] + 2], 32'h0077_0008);
      chk("R7 alt spare copied", mem[ALT[11:2] + 3], 32'h5A2);
      chk("R7 alt src copied", mem[ALT[11:2]], 32'hA2);
      chk("R8 last task wb", mem[ALT[11:2] + 2], 32'h0003_0000);
      chk("R8 ends on alt", 32'(active_alt), 1);

      // R9: memory list (mode 4) with flag set gives no burst
      slot(PRI, LST + 44, ALT + 12, mkctl(4, 12, 1, 0), 0);
      push("R9 m task0", 32'hA0, 32'hB0, mkctl(5, 3, 0, 1), 1, 0);
      push("R9 m task1", 32'hA1, 32'hB1, mkctl(7, 2, 0, 2), 1, 0);
      push("R9 m task2", 32'hA2, 32'hB2, mkctl(1, 6, 0, 3), 1, 0);
      run(0, "R9");
      chk("R7 list untouched", mem[(LST[11:2]) + 2], mkctl(5, 3, 0, 1));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule